// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a small CPU program its own flash memory. Software first arms a command by writing an 8-bit control/status register. It then issues a store strobe that carries a 16-bit data word and a pointer. The controller decodes which command was armed and carries it out. A command can load one word into a 64-entry page buffer, erase a page, program a page from the buffer, set the protection (lock) byte, or give reads back to the section that can be read while another part of the flash is being written. An arming lasts only a short window of cycles. During that window the lock byte or the fuse byte can also be read back.

Erase and program run against a modelled flash array, which answers after a fixed number of cycles set by a parameter. A page program first streams the whole buffer out on a valid/ready interface, word 0 first. The stream may be back-pressured at any word: while `pw_valid` is high and `pw_ready` is low, the word index, the data and the page hold still, and the controller waits. Pages below `RWW_PAGES` belong to the read-while-write section. An operation on such a page raises a busy flag. An operation on any higher page halts the CPU until the operation completes. A global interrupt flag combines with the register's enable bit to request an interrupt whenever the controller is ready for a new command.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00, `irq`, `halt` and `pw_valid` are low, and `lock_bits` holds 0xFF.
- R2: Register layout: bit 7 is the interrupt enable, written by every register write. Bit 6 is the busy flag and cannot be written. Bit 5 always reads 0. Bits 4..0 are the command field, with bit 0 as the enable. Only five values of bits 4..0 take effect: 10001 (read re-enable), 01001 (lock set), 00101 (page program), 00011 (page erase) and 00001 (buffer load). Any other value leaves bits 4..0 unchanged.
- R3: An arming stays visible in bits 4..0 for exactly four cycles after the write. A strobe in any of those four cycles executes the command. If no strobe arrives, the field reads 0 from the fifth cycle onward, and a later strobe is ignored.
- R4: A buffer load stores `spm_data` in the entry given by `spm_ptr[6:1]` and ignores `spm_ptr[0]`. The command field clears in the cycle after the strobe.
- R5: For an erase or a program, the enable bit and the command bit stay set until the flash reports completion. With `pw_ready` held high, the enable bit stays high for ERASE_CYC+1 cycles after the strobe for an erase, and for WRITE_CYC+65 cycles for a program.
- R6: A page program streams 64 words with indices 0 to 63 in order. `pw_page` equals `spm_ptr[13:7]`. Index, data and page stay stable while `pw_valid` is high and `pw_ready` is low.
- R7: An erase or program of a page below RWW_PAGES sets bit 6. Completion of the operation leaves bit 6 set. Bit 6 clears when a read re-enable command executes or when a buffer load executes.
- R8: A register write made while an erase or a program is in progress changes neither bits 4..0 nor bit 6.
- R9: `halt` is high from the cycle after the strobe until completion for any erase or program of a page at or above RWW_PAGES, and low at all other times.
- R10: Writing 10001 into bits 4..0 while no operation runs discards every loaded buffer word. Any entry that is not loaded again is then streamed as 0xFFFF.
- R11: `irq` equals bit 7 AND `gie` AND NOT bit 0.
- R12: A lock-set strobe copies `spm_data[7:0]` to `lock_bits`. A `lk_rd` pulse in the first three cycles of a lock-set arming gives `rd_valid` one cycle later, with `rd_data` set to `lock_bits` when `spm_ptr[0]` is 0 and to FUSE_VAL when it is 1. A pulse in the fourth cycle gives no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write value |
| csr_rdata | output | 8 | Register read value |
| gie | input | 1 | CPU global interrupt flag |
| spm_go | input | 1 | Store strobe |
| spm_data | input | 16 | Data word carried by the strobe |
| spm_ptr | input | 14 | Pointer: bits 13..7 page, 6..1 word, 0 byte or read select |
| lk_rd | input | 1 | Lock or fuse read request |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Lock or fuse byte |
| pw_valid | output | 1 | Program stream word valid |
| pw_ready | input | 1 | Program stream accept |
| pw_idx | output | 6 | Word index in the page |
| pw_page | output | 7 | Page being programmed |
| pw_data | output | 16 | Word value (0xFFFF when not loaded) |
| halt | output | 1 | CPU halt request |
| irq | output | 1 | Ready interrupt request |
| lock_bits | output | 8 | Current lock byte |

## Verification
The in-line assertions check, on every cycle, the properties that are local in time. The enable bit stays set while the flash is working, and `halt` only appears during an operation. The stream holds still under back-pressure, and an arming that expires clears the command field. Bit 6 falls only after a load or re-enable executes, and an illegal write from idle leaves the field at zero. The exact number of cycles the enable bit stays high, the boundary of the four-cycle strobe window, and the three-cycle read window can only be shown by the bench's timed scenarios. The same holds for word contents after an abort and for the choice between busy flag and halt at the section boundary. The bench sweeps all 32 values of the command field and checks each against the five legal patterns.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_STREAM, ST_WAIT} sp_state_t;

  localparam logic [4:0] CMD_FILL  = 5'b00001;
  localparam logic [4:0] CMD_ERASE = 5'b00011;
  localparam logic [4:0] CMD_WRITE = 5'b00101;
  localparam logic [4:0] CMD_LOCK  = 5'b01001;
  localparam logic [4:0] CMD_RWW   = 5'b10001;

  function automatic logic cmd_legal(input logic [4:0] c);
    return (c == CMD_FILL) || (c == CMD_ERASE) || (c == CMD_WRITE) ||
           (c == CMD_LOCK) || (c == CMD_RWW);
  endfunction
endpackage

// File: rtl/selfprog_pagebuf.sv
module selfprog_pagebuf #(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]    mem [WORDS];
  logic [WORDS-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  assign rd_data = vld[rd_idx] ? mem[rd_idx] : {DW{1'b1}};

  // R10: after an abort no entry counts as loaded
  p_abort_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));
endmodule

// File: rtl/selfprog_flash_model.sv
module selfprog_flash_model #(
  parameter int ERASE_CYC = 20,
  parameter int WRITE_CYC = 30,
  localparam int MAXC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_write,
  output logic done
);
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= is_write ? CW'(WRITE_CYC - 1) : CW'(ERASE_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R5: the controller never launches a second operation over a running one
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int          WORDS     = 64,
  parameter int          PAGE_W    = 7,
  parameter int          RWW_PAGES = 112,
  parameter int          WIN       = 4,
  parameter int          RD_WIN    = 3,
  parameter int          ERASE_CYC = 20,
  parameter int          WRITE_CYC = 30,
  parameter logic [7:0]  FUSE_VAL  = 8'h62,
  parameter logic [7:0]  LOCK_INIT = 8'hFF,
  localparam int IDX_W = $clog2(WORDS),
  localparam int PTR_W = IDX_W + PAGE_W + 1,
  localparam int WIN_W = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              gie,
  input  logic              spm_go,
  input  logic [15:0]       spm_data,
  input  logic [PTR_W-1:0]  spm_ptr,
  input  logic              lk_rd,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              pw_valid,
  input  logic              pw_ready,
  output logic [IDX_W-1:0]  pw_idx,
  output logic [PAGE_W-1:0] pw_page,
  output logic [15:0]       pw_data,
  output logic              halt,
  output logic              irq,
  output logic [7:0]        lock_bits
);
  sp_state_t         state;
  logic [4:0]        cmd;
  logic              ie, rwwsb;
  logic [WIN_W-1:0]  win_cnt;
  logic [IDX_W-1:0]  widx;
  logic [PAGE_W-1:0] op_page;
  logic              start_q, fl_done;

  wire               can_arm   = (state == ST_IDLE) || (state == ST_ARMED);
  wire               exec      = (state == ST_ARMED) && spm_go;
  wire               arm_ok    = can_arm && csr_wr && cmd_legal(csr_wdata[4:0]) && !exec;
  wire               abort     = arm_ok && (csr_wdata[4:0] == CMD_RWW);
  wire               do_fill   = exec && (cmd == CMD_FILL);
  wire [IDX_W-1:0]   ptr_word  = spm_ptr[IDX_W:1];
  wire [PAGE_W-1:0]  ptr_page  = spm_ptr[PTR_W-1:IDX_W+1];
  wire               rww_hit   = int'(ptr_page) < RWW_PAGES;
  wire               last_word = (widx == IDX_W'(WORDS - 1));

  selfprog_pagebuf #(.WORDS(WORDS), .DW(16)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(do_fill), .wr_idx(ptr_word), .wr_data(spm_data),
    .clr(abort), .rd_idx(widx), .rd_data(pw_data)
  );

  selfprog_flash_model #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_flash (
    .clk(clk), .rst_n(rst_n), .start(start_q),
    .is_write(cmd[2]), .done(fl_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd       <= '0;
      ie        <= 1'b0;
      rwwsb     <= 1'b0;
      win_cnt   <= '0;
      widx      <= '0;
      op_page   <= '0;
      start_q   <= 1'b0;
      halt      <= 1'b0;
      lock_bits <= LOCK_INIT;
    end else begin
      start_q <= 1'b0;
      if (csr_wr) ie <= csr_wdata[7];
      unique case (state)
        ST_IDLE, ST_ARMED: begin
          if (exec) begin
            unique case (cmd)
              CMD_ERASE, CMD_WRITE: begin
                op_page <= ptr_page;
                if (rww_hit) rwwsb <= 1'b1;
                else         halt  <= 1'b1;
                if (cmd == CMD_ERASE) begin
                  state   <= ST_WAIT;
                  start_q <= 1'b1;
                end else begin
                  state <= ST_STREAM;
                  widx  <= '0;
                end
              end
              CMD_LOCK: begin
                lock_bits <= spm_data[7:0];
                cmd       <= '0;
                state     <= ST_IDLE;
              end
              default: begin
                if (cmd == CMD_FILL || cmd == CMD_RWW) rwwsb <= 1'b0;
                cmd   <= '0;
                state <= ST_IDLE;
              end
            endcase
          end else if (arm_ok) begin
            cmd     <= csr_wdata[4:0];
            win_cnt <= '0;
            state   <= ST_ARMED;
          end else if (state == ST_ARMED) begin
            if (win_cnt == WIN_W'(WIN - 1)) begin
              cmd   <= '0;
              state <= ST_IDLE;
            end else begin
              win_cnt <= win_cnt + 1'b1;
            end
          end
        end
        ST_STREAM: begin
          if (pw_ready) begin
            if (last_word) begin
              state   <= ST_WAIT;
              start_q <= 1'b1;
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (fl_done) begin
            state <= ST_IDLE;
            cmd   <= '0;
            halt  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (lk_rd && state == ST_ARMED && cmd == CMD_LOCK && int'(win_cnt) < RD_WIN) begin
        rd_valid <= 1'b1;
        rd_data  <= spm_ptr[0] ? FUSE_VAL : lock_bits;
      end
    end
  end

  assign csr_rdata = {ie, rwwsb, 1'b0, cmd};
  assign irq       = ie && gie && !cmd[0];
  assign pw_valid  = (state == ST_STREAM);
  assign pw_idx    = widx;
  assign pw_page   = op_page;

  // R5: completion only arrives while the enable and an operation bit are set
  p_done_with_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_done |-> (cmd[0] && (cmd[1] || cmd[2])));
  // R9: halt never outlives the operation
  p_halt_in_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (state == ST_STREAM || state == ST_WAIT));
  // R6: back-pressured word holds still
  p_stream_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && !pw_ready) |=> (pw_valid && $stable(pw_idx) && $stable(pw_data) && $stable(pw_page)));
  // R3: last window cycle without strobe or rewrite empties the field
  p_window_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !spm_go && !csr_wr && win_cnt == WIN_W'(WIN - 1)) |=> (cmd == 5'b0));
  // R7: busy flag falls only after a load or a re-enable executes
  p_rwwsb_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rwwsb) |-> $past(exec && (cmd == CMD_FILL || cmd == CMD_RWW)));
  // R2: illegal value written from idle leaves the field empty
  p_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && csr_wr && !cmd_legal(csr_wdata[4:0])) |=> (cmd == 5'b0));
  // R11: no request while the enable bit is set
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[0] |-> !irq);
  // R12: a read result always answers a request
  p_rd_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(lk_rd));
endmodule

// File: tb/selfprog_ctrl_bench.sv
module selfprog_ctrl_bench;
  localparam int ERASE_CYC = 20;
  localparam int WRITE_CYC = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0, gie = 1'b0, spm_go = 1'b0, lk_rd = 1'b0, pw_ready = 1'b1;
  logic [7:0]  csr_wdata = '0;
  logic [15:0] spm_data = '0;
  logic [13:0] spm_ptr = '0;
  logic [7:0]  csr_rdata, rd_data, lock_bits;
  logic        rd_valid, pw_valid, halt, irq;
  logic [5:0]  pw_idx;
  logic [6:0]  pw_page;
  logic [15:0] pw_data;

  selfprog_ctrl u_selfprog_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .gie(gie), .spm_go(spm_go), .spm_data(spm_data), .spm_ptr(spm_ptr), .lk_rd(lk_rd),
    .rd_valid(rd_valid), .rd_data(rd_data), .pw_valid(pw_valid), .pw_ready(pw_ready),
    .pw_idx(pw_idx), .pw_page(pw_page), .pw_data(pw_data), .halt(halt), .irq(irq),
    .lock_bits(lock_bits)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // stream monitor and ready pattern
  logic [15:0] cap [64];
  logic [6:0]  cap_page;
  int          cap_n = 0;
  bit          bp_mode = 1'b0;
  int          bp_cnt = 0;
  always @(negedge clk) begin
    if (pw_valid && pw_ready) begin
      chk("R6 word order", 32'(pw_idx), 32'(cap_n));
      cap[pw_idx] = pw_data;
      cap_page    = pw_page;
      cap_n++;
    end
    bp_cnt++;
    pw_ready = !bp_mode || (bp_cnt % 3 != 0);
  end

  task automatic wr_csr(input logic [7:0] v);
    csr_wdata = v; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic strobe(input int d, input logic [15:0] dat, input logic [13:0] ptr);
    repeat (d) @(negedge clk);
    spm_data = dat; spm_ptr = ptr; spm_go = 1'b1;
    @(negedge clk);
    spm_go = 1'b0;
  endtask

  task automatic lkread(input logic sel);
    spm_ptr[0] = sel; lk_rd = 1'b1;
    @(negedge clk);
    lk_rd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (csr_rdata[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(16'h1000 + i * 16'h0123);
  endfunction

  function automatic logic is_legal(input int v);
    return v == 1 || v == 3 || v == 5 || v == 9 || v == 17;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    wrap_up();
  end

  initial begin
    int n;
    logic [7:0] lk_prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 csr", 32'(csr_rdata), 32'h00);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 halt", 32'(halt), 0);
    chk("R1 pw_valid", 32'(pw_valid), 0);
    chk("R1 lock", 32'(lock_bits), 32'hFF);

    // R2/R3 sweep of the command field, bits 6 and 5 also driven high
    for (int v = 0; v < 32; v++) begin
      wr_csr({3'b011, 5'(v)});
      chk("R2 legal decode", 32'(csr_rdata), is_legal(v) ? 32'(v) : 32'h0);
      repeat (3) @(negedge clk);
      chk("R3 fourth cycle", 32'(csr_rdata[4:0]), is_legal(v) ? 32'(v) : 32'h0);
      @(negedge clk);
      chk("R3 expiry", 32'(csr_rdata[4:0]), 0);
    end

    // R3 strobe window edge via lock set (R12)
    lk_prev = lock_bits;
    for (int d = 0; d <= 4; d++) begin
      wr_csr(8'h09);
      strobe(d, 16'(16'h00A0 + d), 14'h3FFF);
      chk("R3 window strobe", 32'(lock_bits), d < 4 ? 32'(8'hA0 + d) : 32'(lk_prev));
      if (d < 4) chk("R12 field cleared", 32'(csr_rdata[4:0]), 0);
      lk_prev = lock_bits;
      repeat (5) @(negedge clk);
    end

    // R12 lock/fuse read window
    wr_csr(8'h09);
    lkread(1'b0);
    chk("R12 lock read valid", 32'(rd_valid), 1);
    chk("R12 lock read data", 32'(rd_data), 32'(lock_bits));
    lkread(1'b1);
    chk("R12 fuse read data", 32'(rd_data), 32'h62);
    lkread(1'b1);
    chk("R12 third cycle valid", 32'(rd_valid), 1);
    lkread(1'b0);
    chk("R12 fourth cycle no read", 32'(rd_valid), 0);
    repeat (3) @(negedge clk);

    // R4 fill the whole buffer, pointer bit 0 set
    for (int i = 0; i < 64; i++) begin
      wr_csr(8'h01);
      strobe(0, pat(i), {7'd5, 6'(i), 1'b1});
      if (i == 0) chk("R4 enable clears", 32'(csr_rdata[4:0]), 0);
    end

    // R5/R6/R7 program an RWW page
    cap_n = 0;
    wr_csr(8'h05);
    strobe(0, 16'hDEAD, {7'd5, 6'd9, 1'b0});
    chk("R7 busy set", 32'(csr_rdata[6]), 1);
    chk("R9 no halt in RWW", 32'(halt), 0);
    wait_idle(n);
    chk("R5 program duration", 32'(n), 32'(WRITE_CYC + 65));
    chk("R6 word count", 32'(cap_n), 64);
    chk("R6 page", 32'(cap_page), 5);
    for (int i = 0; i < 64; i++) chk("R4 R6 word data", 32'(cap[i]), 32'(pat(i)));
    chk("R7 busy kept after done", 32'(csr_rdata[6]), 1);
    wr_csr(8'h11);
    strobe(0, 16'h0, 14'h0);
    chk("R7 re-enable clears", 32'(csr_rdata[6]), 0);

    // R5 erase duration on RWW page
    wr_csr(8'h03);
    strobe(0, 16'h0, {7'd2, 7'd0});
    chk("R7 erase busy", 32'(csr_rdata[6]), 1);
    wait_idle(n);
    chk("R5 erase duration", 32'(n), 32'(ERASE_CYC + 1));

    // R8 re-enable during erase ignored
    wr_csr(8'h03);
    strobe(0, 16'h0, {7'd3, 7'd0});
    wr_csr(8'h11);
    chk("R8 field unchanged", 32'(csr_rdata[4:0]), 32'h03);
    wait_idle(n);
    chk("R8 busy kept", 32'(csr_rdata[6]), 1);
    wr_csr(8'h01);
    strobe(0, 16'h1234, {7'd0, 6'd0, 1'b0});
    chk("R7 load clears busy", 32'(csr_rdata[6]), 0);

    // R9 erase above the boundary halts
    wr_csr(8'h03);
    strobe(0, 16'h0, {7'd127, 7'd0});
    chk("R9 halt on", 32'(halt), 1);
    chk("R9 no busy flag", 32'(csr_rdata[6]), 0);
    wait_idle(n);
    chk("R5 erase duration high page", 32'(n), 32'(ERASE_CYC + 1));
    chk("R9 halt off", 32'(halt), 0);

    // R10 abort, reload one word, program boundary page 112 under back-pressure
    for (int i = 0; i < 10; i++) begin
      wr_csr(8'h01);
      strobe(0, 16'(16'h5500 + i), {7'd0, 6'(i), 1'b0});
    end
    wr_csr(8'h11);
    repeat (5) @(negedge clk);
    wr_csr(8'h01);
    strobe(0, 16'h7777, {7'd0, 6'd3, 1'b0});
    bp_mode = 1'b1;
    cap_n = 0;
    wr_csr(8'h05);
    strobe(0, 16'h0, {7'd112, 7'd0});
    chk("R9 halt on boundary page", 32'(halt), 1);
    wait_idle(n);
    bp_mode = 1'b0;
    chk("R9 halt released", 32'(halt), 0);
    chk("R6 bp word count", 32'(cap_n), 64);
    chk("R6 bp page", 32'(cap_page), 112);
    for (int i = 0; i < 64; i++)
      chk("R10 abort data", 32'(cap[i]), i == 3 ? 32'h7777 : 32'hFFFF);

    // R11 interrupt request
    gie = 1'b1;
    wr_csr(8'h80);
    chk("R11 irq on", 32'(irq), 1);
    chk("R2 illegal keeps field", 32'(csr_rdata[4:0]), 0);
    wr_csr(8'h81);
    chk("R11 irq off while enabled", 32'(irq), 0);
    repeat (4) @(negedge clk);
    chk("R11 irq after expiry", 32'(irq), 1);
    gie = 1'b0;
    #1;
    chk("R11 irq gated by gie", 32'(irq), 0);
    @(negedge clk);
    wr_csr(8'h00);

    wrap_up();
  end
endmodule